// File: doc/BRIEF.md
# Descriptor CRC-32 Stream Engine

This block computes a 32-bit cyclic redundancy check over a stream of bytes. It uses the generator 0x20044009 (x^32 + x^29 + x^18 + x^14 + x^3 + 1), which is not one of the common CRC-32 generators. The intended use is sealing and verifying command descriptors. One byte can be accepted on every clock. The running remainder appears on the output one cycle after each byte is taken, with no output inversion and no bit reflection.

A start strobe loads a seed. The seed is normally all ones. It can also be a remainder captured earlier, so a message can be processed in several separate pieces and chained back together. When the start strobe and a valid byte arrive in the same cycle, the seed is loaded and that byte is folded in at once. No cycle is lost at the head of a message. A stream may have any length, including zero bytes.

Top module: `desc_crc32`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the remainder is set to 0xFFFFFFFF. `crc_o` shows that value from the next cycle onward, until a byte or a start strobe is accepted.
- R2: When `start_i` is high and `byte_vld_i` is low, `crc_o` equals `seed_i` one cycle later.
- R3: When `byte_vld_i` is high and `start_i` is low, `crc_o` one cycle later equals the fold of the previous `crc_o` with `byte_i`. To fold, XOR the byte into bits 31:24 of the remainder. Then apply eight steps. In each step, shift left by one; if bit 31 was set before the shift, also XOR in 0x20044009.
- R4: Starting from the seed 0xFFFFFFFF, the bytes 0x01, 0x02, 0x03, 0x04 give a remainder of 0xF33CB7D3.
- R5: When `start_i` and `byte_vld_i` are both high, `crc_o` one cycle later equals the fold of `seed_i` with `byte_i`. The old remainder has no effect.
- R6: In any cycle where both `start_i` and `byte_vld_i` are low, `crc_o` keeps its value, whatever `byte_i` and `seed_i` carry.
- R7: The byte enters at the most significant end, and the output is not reflected or inverted. From seed 0, byte 0x01 gives 0x20044009 and byte 0x80 gives 0x426C8402. When the top byte of the remainder XOR the data byte is zero, the fold is a plain left shift by eight.
- R8: A message can be split at any byte boundary. Restart with `start_i` and `seed_i` set to the remainder of the first part, and the final result equals that of the unbroken message.
- R9: A start strobe with no byte following it (an empty message) leaves `crc_o` equal to the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; sets remainder to 0xFFFFFFFF |
| start_i | input | 1 | Load `seed_i` as the remainder for a new message or a resumed segment |
| seed_i | input | 32 | Seed value taken when `start_i` is high |
| byte_vld_i | input | 1 | `byte_i` carries a byte to be folded in this cycle |
| byte_i | input | 8 | Message byte |
| crc_o | output | 32 | Running remainder, registered |

## Verification
Every result has a latency of exactly one clock: a seed load, a byte fold, or a start with a byte all show on `crc_o` one clock after the rising edge that captured them. A held value stays unchanged through every idle edge. The bench changes its inputs on the falling edge. It compares `crc_o` on the following falling edge, half a period after the capturing edge, so each comparison sees exactly one register update. In the hold tests, the value is sampled again after each idle edge while `byte_i` and `seed_i` change. The expected remainders come from a bitwise model in the bench that follows R3. The fixed values from R4 and R7 are also checked literally.

// File: rtl/desc_crc32_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, types and a helper that folds one index byte.
// Assumes an MSB-first, non-reflected CRC with no output XOR.
package desc_crc32_pkg;
    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Fold style selectors
    localparam int FOLD_BITCHAIN = 0;
    localparam int FOLD_LOOKUP   = 1;

    // Remainder contributed by one index byte placed at the top of a zero register
    function automatic crc_t lut_entry(input byte_t idx, input crc_t poly);
        crc_t r;
        r = {idx, {(CRC_W-BYTE_W){1'b0}}};
        for (int k = 0; k < BYTE_W; k++) begin
            r = r[CRC_W-1] ? ((r << 1) ^ poly) : (r << 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/desc_crc32_bit_step.sv
`timescale 1ns/1ps
// Module: one bit of CRC division. Shifts left one place and, when the
// outgoing MSB was set, subtracts (XORs) the generator.
// Assumes the data bit has already been merged into the remainder.
module desc_crc32_bit_step
    import desc_crc32_pkg::*;
#(
    parameter crc_t POLY = 32'h2004_4009
) (
    input  crc_t rem_i,
    output crc_t rem_o
);
    // Conditional generator subtraction after the shift
    always_comb begin
        rem_o = {rem_i[CRC_W-2:0], 1'b0} ^ (rem_i[CRC_W-1] ? POLY : '0);
    end
endmodule

// File: rtl/desc_crc32_byte_fold.sv
`timescale 1ns/1ps
// Module: folds one byte into a remainder, MSB-first.
// STYLE picks the structure: an unrolled chain of eight bit steps, or
// a 256-way lookup on the top byte combined with an 8-bit shift.
// Assumes purely combinational use; the caller registers the result.
module desc_crc32_byte_fold
    import desc_crc32_pkg::*;
#(
    parameter crc_t POLY  = 32'h2004_4009,
    parameter int   STYLE = FOLD_BITCHAIN
) (
    input  crc_t  rem_i,
    input  byte_t data_i,
    output crc_t  rem_o
);
    generate
        if (STYLE == FOLD_LOOKUP) begin : g_lookup
            byte_t idx;
            // Index from remainder top byte and incoming data
            always_comb begin
                idx   = rem_i[CRC_W-1 -: BYTE_W] ^ data_i;
                rem_o = {rem_i[CRC_W-BYTE_W-1:0], {BYTE_W{1'b0}}} ^ lut_entry(idx, POLY);
            end
        end else begin : g_chain
            crc_t stage [BYTE_W+1];
            // Merge the byte into the top of the remainder
            always_comb begin
                stage[0] = rem_i ^ {data_i, {(CRC_W-BYTE_W){1'b0}}};
            end
            for (genvar s = 0; s < BYTE_W; s++) begin : g_step
                desc_crc32_bit_step #(.POLY(POLY)) u_step (
                    .rem_i (stage[s]),
                    .rem_o (stage[s+1])
                );
            end
            // Last stage is the folded remainder
            always_comb begin
                rem_o = stage[BYTE_W];
            end
        end
    endgenerate
endmodule

// File: rtl/desc_crc32.sv
`timescale 1ns/1ps
// Module: byte-serial CRC-32 engine (generator 0x20044009, MSB-first,
// no reflection, no final XOR). A start strobe loads a seed; a start
// together with a valid byte folds that byte into the seed at once.
// Assumes a synchronous active-low reset; crc_o is registered.
module desc_crc32
    import desc_crc32_pkg::*;
#(
    parameter crc_t RST_SEED   = 32'hFFFF_FFFF,
    parameter crc_t POLY       = 32'h2004_4009,
    parameter int   FOLD_STYLE = FOLD_BITCHAIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CRC_W-1:0]  seed_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [CRC_W-1:0]  crc_o
);
    crc_t rem_q;
    crc_t fold_base;
    crc_t fold_res;

    // Base for the fold: a fresh seed on start, else the running remainder
    always_comb begin
        fold_base = start_i ? seed_i : rem_q;
    end

    desc_crc32_byte_fold #(.POLY(POLY), .STYLE(FOLD_STYLE)) u_fold (
        .rem_i  (fold_base),
        .data_i (byte_i),
        .rem_o  (fold_res)
    );

    // Remainder register: reset, fold, seed load or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= RST_SEED;
        end else if (byte_vld_i) begin
            rem_q <= fold_res;
        end else if (start_i) begin
            rem_q <= seed_i;
        end
    end

    assign crc_o = rem_q;

    // R1: first cycle out of reset shows the reset seed
    p_reset_seed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (crc_o == RST_SEED));

    // R2: a bare start loads the seed
    p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !byte_vld_i) |=> (crc_o == $past(seed_i)));

    // R6: idle cycles keep the remainder
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !byte_vld_i) |=> $stable(crc_o));

    // R7: zero lookup index on a running fold reduces to a shift by eight
    p_zero_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && !start_i && (byte_i == crc_o[CRC_W-1 -: BYTE_W]))
        |=> (crc_o == {$past(crc_o[CRC_W-BYTE_W-1:0]), {BYTE_W{1'b0}}}));

    // R5: start with a byte folds into the seed, not the old remainder
    p_start_fold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && byte_vld_i && (byte_i == seed_i[CRC_W-1 -: BYTE_W]))
        |=> (crc_o == {$past(seed_i[CRC_W-BYTE_W-1:0]), {BYTE_W{1'b0}}}));
endmodule

// File: tb/desc_crc32_bench.sv
`timescale 1ns/1ps
module desc_crc32_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] seed_i = '0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [31:0] crc_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    desc_crc32 u_desc_crc32 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .seed_i     (seed_i),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .crc_o      (crc_o)
    );

    // Bitwise reference following R3
    function automatic logic [31:0] ref_fold(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {b, 24'h0};
        for (int k = 0; k < 8; k++) r = r[31] ? ((r << 1) ^ 32'h2004_4009) : (r << 1);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        n_checks++;
        if (crc_o !== exp) begin
            n_fail++;
            $display("FAIL %s: crc_o=%08h expected=%08h", req, crc_o, exp);
        end
    endtask

    // Drive one cycle of inputs at negedge, return at the next negedge
    task automatic cyc(input bit s, input logic [31:0] sd, input bit v, input logic [7:0] b);
        start_i = s; seed_i = sd; byte_vld_i = v; byte_i = b;
        @(negedge clk);
        start_i = 1'b0; byte_vld_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(1'b0, 32'h1234_5678, 1'b1, 8'h5A);   // byte ignored in reset
        cyc(1'b0, 32'h0, 1'b0, 8'h00);
        check("R1 in reset", 32'hFFFF_FFFF);
        rst_n = 1'b1;
        cyc(1'b0, 32'h0, 1'b0, 8'h00);
        check("R1 after release", 32'hFFFF_FFFF);
    endtask

    task automatic t_check_value();
        logic [31:0] m;
        m = ref_fold(32'hFFFF_FFFF, 8'h01);
        cyc(1'b1, 32'hFFFF_FFFF, 1'b1, 8'h01);
        check("R5 start with first byte", m);
        cyc(1'b0, 32'h0, 1'b1, 8'h02); m = ref_fold(m, 8'h02);
        check("R3 second byte", m);
        cyc(1'b0, 32'h0, 1'b1, 8'h03);
        cyc(1'b0, 32'h0, 1'b1, 8'h04);
        check("R4 check value", 32'hF33C_B7D3);
    endtask

    task automatic t_start_only();
        cyc(1'b1, 32'h1234_5678, 1'b0, 8'hAA);
        check("R2 seed load", 32'h1234_5678);
        cyc(1'b0, 32'hDEAD_BEEF, 1'b0, 8'h00);
        check("R9 empty message keeps seed", 32'h1234_5678);
    endtask

    task automatic t_hold();
        logic [31:0] held;
        held = crc_o;
        for (int i = 0; i < 5; i++) begin
            cyc(1'b0, 32'hA5A5_0000 + i, 1'b0, 8'(i * 37));
            check("R6 hold while idle", held);
        end
    endtask

    task automatic t_stream();
        logic [31:0] m;
        logic [7:0]  lf;
        lf = 8'hB7;
        m = 32'hFFFF_FFFF;
        cyc(1'b1, m, 1'b0, 8'h00);
        for (int i = 0; i < 40; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            m = ref_fold(m, lf);
            cyc(1'b0, 32'h0, 1'b1, lf);
            check("R3 streamed byte", m);
            if (i % 9 == 4) begin
                cyc(1'b0, 32'h0, 1'b0, ~lf);
                check("R6 gap in stream", m);
            end
        end
    endtask

    task automatic t_msb_first();
        cyc(1'b1, 32'h0, 1'b1, 8'h01);
        check("R7 seed 0 byte 01", 32'h2004_4009);
        cyc(1'b1, 32'h0, 1'b1, 8'h80);
        check("R7 seed 0 byte 80", 32'h426C_8402);
        cyc(1'b1, 32'h3C00_0001, 1'b0, 8'h00);
        cyc(1'b0, 32'h0, 1'b1, 8'h3C);
        check("R7 zero index shifts by eight", 32'h0000_0100);
    endtask

    task automatic t_start_fold();
        cyc(1'b1, 32'h0BAD_F00D, 1'b0, 8'h00);
        cyc(1'b1, 32'h5555_AAAA, 1'b1, 8'hC3);
        check("R5 start overrides old remainder", ref_fold(32'h5555_AAAA, 8'hC3));
    endtask

    task automatic t_chain();
        logic [31:0] m;
        logic [31:0] part;
        logic [7:0]  msg [12];
        for (int i = 0; i < 12; i++) msg[i] = 8'(8'h11 * i + 8'h07);
        m = 32'hFFFF_FFFF;
        for (int i = 0; i < 12; i++) m = ref_fold(m, msg[i]);
        cyc(1'b1, 32'hFFFF_FFFF, 1'b1, msg[0]);
        for (int i = 1; i < 5; i++) cyc(1'b0, 32'h0, 1'b1, msg[i]);
        part = crc_o;
        cyc(1'b1, 32'hFFFF_FFFF, 1'b1, 8'h99);   // unrelated message in between
        cyc(1'b1, part, 1'b1, msg[5]);
        for (int i = 6; i < 12; i++) cyc(1'b0, 32'h0, 1'b1, msg[i]);
        check("R8 chained segments", m);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_check_value();
        t_start_only();
        t_hold();
        t_stream();
        t_msb_first();
        t_start_fold();
        t_chain();
        t_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule